// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block holds a small circular store queue and answers load lookups against it. Each queue slot keeps a virtual line address, a physical line address, a byte-enable mask, a flag that makes the store cover its whole line, the store bytes, and three state bits: allocated, address known and data present. Separate write ports fill in the address side and the data side of a slot, and a release port frees it.

A load lookup carries its virtual and physical line addresses, the byte lanes it needs, its own position in the store queue, and a bit vector, decoded earlier by the requester, that marks which slots hold stores older than the load. For every requested lane the block finds the youngest older store that covers it and returns that store's byte. The answer comes in two stages: an early lane mask and an early data-not-ready flag, then the full mask, the bytes and the replay and flush flags one cycle later. The load pipeline uses the flags to replay a load whose forwarding source has no data yet, to replay a load behind a store of unknown address, and to flush when virtual and physical matching disagree.

Top module: `stlf_forward`

## Requirements
- R1: For each lane b with q_mask[b]=1, fwd_mask[b]=1 and fwd_data[8b+7:8b] equals that store's byte b when the youngest older matching store covering lane b has its data present; lanes outside q_mask are never forwarded.
- R2: A slot takes part in matching only if it is allocated, has a known address, has its bit set in q_older, its virtual line equals q_vline, and its effective byte mask overlaps q_mask.
- R3: When several matching older stores cover one lane, the one nearest below q_pos wins, scanning q_pos-1, q_pos-2 and on, wrapping from slot 0 to the highest slot.
- R4: The early mask and early data-not-ready flag appear one clock edge after the lookup is sampled; the full mask, bytes and all final flags appear two edges after.
- R5: If a lane's winning store has no data yet, the lane is not forwarded, data_wait and fast_data_wait are raised, and data_wait_idx names the youngest such winner.
- R6: If any allocated older slot has an unknown address, addr_wait is raised and addr_wait_idx names the youngest such slot.
- R7: match_bad is raised when, over the older slots with known address, the set matching by virtual line differs from the set matching by physical line (same overlap rule).
- R8: A store written with its line-cover flag set acts as if its byte mask were all ones.
- R9: A cycle with q_valid low yields all-zero masks, zero data and every flag low in both stages.
- R10: After reset the queue is empty and every output is zero.
- R11: A released slot no longer takes part in forwarding or in any flag.
- R12: fwd_data lanes whose fwd_mask bit is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_addr_valid | input | 1 | Allocate/write address side of a slot |
| wr_addr_idx | input | IDXW | Slot written |
| wr_addr_known | input | 1 | 1: address fields valid; 0: slot allocated with address unknown |
| wr_vline | input | LINE_W | Store virtual line address |
| wr_pline | input | LINE_W | Store physical line address |
| wr_mask | input | BYTES | Store byte mask |
| wr_line_cover | input | 1 | Store covers every lane of its line |
| wr_data_valid | input | 1 | Write data side of a slot |
| wr_data_idx | input | IDXW | Slot whose data is written |
| wr_data | input | 8*BYTES | Store bytes, lane b at bits 8b+7:8b |
| rel_valid | input | 1 | Release a slot |
| rel_idx | input | IDXW | Slot released |
| q_valid | input | 1 | Lookup present |
| q_vline | input | LINE_W | Load virtual line address |
| q_pline | input | LINE_W | Load physical line address |
| q_mask | input | BYTES | Lanes the load needs |
| q_older | input | ENTRIES | Bit e set: slot e is older than the load |
| q_pos | input | IDXW | Load position in the store queue |
| fast_fwd_mask | output | BYTES | Early forward mask |
| fast_data_wait | output | 1 | Early data-not-ready flag |
| fwd_mask | output | BYTES | Final forward mask |
| fwd_data | output | 8*BYTES | Forwarded bytes |
| data_wait | output | 1 | Replay: winning store data missing |
| data_wait_idx | output | IDXW | Slot causing data_wait |
| addr_wait | output | 1 | Replay: older store address unknown |
| addr_wait_idx | output | IDXW | Slot causing addr_wait |
| match_bad | output | 1 | Virtual/physical match disagreement |

## Verification
A lookup sampled at one rising edge has its early mask and early wait flag due after that edge and everything else due after the next one. The bench changes inputs on falling edges, holds q_valid for exactly one cycle, reads the early outputs at the first falling edge after the sampling edge and the final outputs at the second, and keeps queue writes out of those windows so the reference model sees the same queue contents the design saw.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

   // Slot reached by stepping k places back from pos in a ring of n slots.
   function automatic int unsigned ring_back(int unsigned pos, int unsigned k, int unsigned n);
      return (pos + n - k) % n;
   endfunction

endpackage

// File: rtl/stlf_store_array.sv
module stlf_store_array #(
   parameter int ENTRIES = 16,
   parameter int BYTES   = 16,
   parameter int LINE_W  = 28,
   localparam int IDXW   = $clog2(ENTRIES)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wa_valid,
   input  logic [IDXW-1:0]                     wa_idx,
   input  logic                                wa_known,
   input  logic [LINE_W-1:0]                   wa_vline,
   input  logic [LINE_W-1:0]                   wa_pline,
   input  logic [BYTES-1:0]                    wa_mask,
   input  logic                                wa_cover,
   input  logic                                wd_valid,
   input  logic [IDXW-1:0]                     wd_idx,
   input  logic [BYTES-1:0][7:0]               wd_bytes,
   input  logic                                fr_valid,
   input  logic [IDXW-1:0]                     fr_idx,
   output logic [ENTRIES-1:0]                  alloc_o,
   output logic [ENTRIES-1:0]                  aok_o,
   output logic [ENTRIES-1:0]                  dok_o,
   output logic [ENTRIES-1:0][LINE_W-1:0]      vline_o,
   output logic [ENTRIES-1:0][LINE_W-1:0]      pline_o,
   output logic [ENTRIES-1:0][BYTES-1:0]       mask_o,
   output logic [ENTRIES-1:0]                  cover_o,
   output logic [ENTRIES-1:0][BYTES-1:0][7:0]  bytes_o
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic hit_a, hit_d, hit_f;
      assign hit_a = wa_valid && (wa_idx == IDXW'(e));
      assign hit_d = wd_valid && (wd_idx == IDXW'(e));
      assign hit_f = fr_valid && (fr_idx == IDXW'(e));

      // state bits: release has priority over a same-cycle write
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            alloc_o[e] <= 1'b0;
            aok_o[e]   <= 1'b0;
            dok_o[e]   <= 1'b0;
         end else if (hit_f) begin
            alloc_o[e] <= 1'b0;
            aok_o[e]   <= 1'b0;
            dok_o[e]   <= 1'b0;
         end else begin
            if (hit_a) begin
               alloc_o[e] <= 1'b1;
               aok_o[e]   <= wa_known;
            end
            if (hit_d) dok_o[e] <= 1'b1;
         end
      end

      // payload
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vline_o[e] <= '0;
            pline_o[e] <= '0;
            mask_o[e]  <= '0;
            cover_o[e] <= 1'b0;
            bytes_o[e] <= '0;
         end else begin
            if (hit_a) begin
               vline_o[e] <= wa_vline;
               pline_o[e] <= wa_pline;
               mask_o[e]  <= wa_mask;
               cover_o[e] <= wa_cover;
            end
            if (hit_d) bytes_o[e] <= wd_bytes;
         end
      end
   end

endmodule

// File: rtl/stlf_entry_match.sv
module stlf_entry_match #(
   parameter int BYTES         = 16,
   parameter int LINE_W        = 28,
   parameter bit LINE_COVER_EN = 1'b1
) (
   input  logic              live,
   input  logic              addr_ok,
   input  logic [LINE_W-1:0] st_vline,
   input  logic [LINE_W-1:0] st_pline,
   input  logic [BYTES-1:0]  st_mask,
   input  logic              st_cover,
   input  logic [LINE_W-1:0] ld_vline,
   input  logic [LINE_W-1:0] ld_pline,
   input  logic [BYTES-1:0]  ld_mask,
   output logic [BYTES-1:0]  eff_mask,
   output logic              vhit,
   output logic              phit
);

   if (LINE_COVER_EN) begin : g_cover
      assign eff_mask = st_cover ? {BYTES{1'b1}} : st_mask;
   end else begin : g_plain
      logic unused_cover;
      assign unused_cover = st_cover;
      assign eff_mask = st_mask;
   end

   logic overlap;
   assign overlap = |(eff_mask & ld_mask);
   assign vhit = live && addr_ok && overlap && (st_vline == ld_vline);
   assign phit = live && addr_ok && overlap && (st_pline == ld_pline);

endmodule

// File: rtl/stlf_age_pick.sv
module stlf_age_pick #(
   parameter int ENTRIES = 16,
   localparam int IDXW   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] req,
   input  logic [IDXW-1:0]    pos,
   output logic               found,
   output logic [IDXW-1:0]    idx
);
   import stlf_pkg::*;

   // scan from the oldest distance to the nearest; the last hit is the youngest
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = ENTRIES; k >= 1; k--) begin
         int unsigned j;
         j = ring_back(int'(pos), k, ENTRIES);
         if (req[j]) begin
            found = 1'b1;
            idx   = IDXW'(j);
         end
      end
   end

endmodule

// File: rtl/stlf_forward.sv
module stlf_forward #(
   parameter int ENTRIES       = 16,
   parameter int BYTES         = 16,
   parameter int LINE_W        = 28,
   parameter bit LINE_COVER_EN = 1'b1,
   localparam int IDXW         = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_addr_valid,
   input  logic [IDXW-1:0]      wr_addr_idx,
   input  logic                 wr_addr_known,
   input  logic [LINE_W-1:0]    wr_vline,
   input  logic [LINE_W-1:0]    wr_pline,
   input  logic [BYTES-1:0]     wr_mask,
   input  logic                 wr_line_cover,
   input  logic                 wr_data_valid,
   input  logic [IDXW-1:0]      wr_data_idx,
   input  logic [8*BYTES-1:0]   wr_data,
   input  logic                 rel_valid,
   input  logic [IDXW-1:0]      rel_idx,
   input  logic                 q_valid,
   input  logic [LINE_W-1:0]    q_vline,
   input  logic [LINE_W-1:0]    q_pline,
   input  logic [BYTES-1:0]     q_mask,
   input  logic [ENTRIES-1:0]   q_older,
   input  logic [IDXW-1:0]      q_pos,
   output logic [BYTES-1:0]     fast_fwd_mask,
   output logic                 fast_data_wait,
   output logic [BYTES-1:0]     fwd_mask,
   output logic [8*BYTES-1:0]   fwd_data,
   output logic                 data_wait,
   output logic [IDXW-1:0]      data_wait_idx,
   output logic                 addr_wait,
   output logic [IDXW-1:0]      addr_wait_idx,
   output logic                 match_bad
);

   // elaboration-time parameter checks
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_chk_entries
      $error("stlf_forward: ENTRIES must be a power of two >= 2");
   end
   if (BYTES < 1) begin : g_chk_bytes
      $error("stlf_forward: BYTES must be >= 1");
   end
   if (LINE_W < 1) begin : g_chk_line
      $error("stlf_forward: LINE_W must be >= 1");
   end

   // ---------------- queue storage ----------------
   logic [ENTRIES-1:0]                 s_alloc, s_aok, s_dok, s_cover;
   logic [ENTRIES-1:0][LINE_W-1:0]     s_vline, s_pline;
   logic [ENTRIES-1:0][BYTES-1:0]      s_mask;
   logic [ENTRIES-1:0][BYTES-1:0][7:0] s_bytes;

   stlf_store_array #(.ENTRIES(ENTRIES), .BYTES(BYTES), .LINE_W(LINE_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wa_valid (wr_addr_valid),
      .wa_idx   (wr_addr_idx),
      .wa_known (wr_addr_known),
      .wa_vline (wr_vline),
      .wa_pline (wr_pline),
      .wa_mask  (wr_mask),
      .wa_cover (wr_line_cover),
      .wd_valid (wr_data_valid),
      .wd_idx   (wr_data_idx),
      .wd_bytes (wr_data),
      .fr_valid (rel_valid),
      .fr_idx   (rel_idx),
      .alloc_o  (s_alloc),
      .aok_o    (s_aok),
      .dok_o    (s_dok),
      .vline_o  (s_vline),
      .pline_o  (s_pline),
      .mask_o   (s_mask),
      .cover_o  (s_cover),
      .bytes_o  (s_bytes)
   );

   // ---------------- stage 1: per-slot match ----------------
   logic [ENTRIES-1:0]            live, vhit, phit;
   logic [ENTRIES-1:0][BYTES-1:0] eff_mask;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_match
      assign live[e] = q_valid && q_older[e] && s_alloc[e];
      stlf_entry_match #(.BYTES(BYTES), .LINE_W(LINE_W), .LINE_COVER_EN(LINE_COVER_EN)) u_match (
         .live     (live[e]),
         .addr_ok  (s_aok[e]),
         .st_vline (s_vline[e]),
         .st_pline (s_pline[e]),
         .st_mask  (s_mask[e]),
         .st_cover (s_cover[e]),
         .ld_vline (q_vline),
         .ld_pline (q_pline),
         .ld_mask  (q_mask),
         .eff_mask (eff_mask[e]),
         .vhit     (vhit[e]),
         .phit     (phit[e])
      );
   end

   // ---------------- stage 1: per-lane youngest pick ----------------
   logic [BYTES-1:0]            lane_found, lane_ok, lane_wait;
   logic [BYTES-1:0][IDXW-1:0]  lane_win;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      logic [ENTRIES-1:0] cand;
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cand
         assign cand[e] = vhit[e] && eff_mask[e][b] && q_mask[b];
      end
      stlf_age_pick #(.ENTRIES(ENTRIES)) u_pick (
         .req   (cand),
         .pos   (q_pos),
         .found (lane_found[b]),
         .idx   (lane_win[b])
      );
      assign lane_ok[b]   = lane_found[b] &&  s_dok[lane_win[b]];
      assign lane_wait[b] = lane_found[b] && !s_dok[lane_win[b]];
   end

   // slots that won a lane but have no data
   logic [ENTRIES-1:0] dwait_vec;
   always_comb begin
      dwait_vec = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         for (int b = 0; b < BYTES; b++) begin
            if (lane_wait[b] && lane_win[b] == IDXW'(e)) dwait_vec[e] = 1'b1;
         end
      end
   end

   logic            dw_found, aw_found;
   logic [IDXW-1:0] dw_idx, aw_idx;
   logic [ENTRIES-1:0] await_vec;
   assign await_vec = live & ~s_aok;

   stlf_age_pick #(.ENTRIES(ENTRIES)) u_pick_dwait (
      .req (dwait_vec), .pos (q_pos), .found (dw_found), .idx (dw_idx)
   );
   stlf_age_pick #(.ENTRIES(ENTRIES)) u_pick_await (
      .req (await_vec), .pos (q_pos), .found (aw_found), .idx (aw_idx)
   );

   // ---------------- stage 1 registers ----------------
   logic [BYTES-1:0][IDXW-1:0] s1_win;
   logic                       s1_aw;
   logic [IDXW-1:0]            s1_dw_idx, s1_aw_idx;
   logic                       s1_mbad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fast_fwd_mask  <= '0;
         fast_data_wait <= 1'b0;
         s1_win         <= '0;
         s1_aw          <= 1'b0;
         s1_dw_idx      <= '0;
         s1_aw_idx      <= '0;
         s1_mbad        <= 1'b0;
      end else begin
         fast_fwd_mask  <= lane_ok;
         fast_data_wait <= dw_found;
         s1_win         <= lane_win;
         s1_aw          <= aw_found;
         s1_dw_idx      <= dw_found ? dw_idx : '0;
         s1_aw_idx      <= aw_found ? aw_idx : '0;
         s1_mbad        <= (vhit != phit);
      end
   end

   // ---------------- stage 2 registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_mask      <= '0;
         fwd_data      <= '0;
         data_wait     <= 1'b0;
         data_wait_idx <= '0;
         addr_wait     <= 1'b0;
         addr_wait_idx <= '0;
         match_bad     <= 1'b0;
      end else begin
         fwd_mask      <= fast_fwd_mask;
         for (int b = 0; b < BYTES; b++) begin
            fwd_data[8*b +: 8] <= fast_fwd_mask[b] ? s_bytes[s1_win[b]][b] : 8'h00;
         end
         data_wait     <= fast_data_wait;
         data_wait_idx <= s1_dw_idx;
         addr_wait     <= s1_aw;
         addr_wait_idx <= s1_aw_idx;
         match_bad     <= s1_mbad;
      end
   end

endmodule

// File: rtl/stlf_forward_chk.sv
module stlf_forward_chk #(
   parameter int ENTRIES = 16,
   parameter int BYTES   = 16,
   parameter int LINE_W  = 28,
   localparam int IDXW   = $clog2(ENTRIES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 q_valid,
   input logic [BYTES-1:0]     q_mask,
   input logic [ENTRIES-1:0]   q_older,
   input logic [BYTES-1:0]     fast_fwd_mask,
   input logic                 fast_data_wait,
   input logic [BYTES-1:0]     fwd_mask,
   input logic [8*BYTES-1:0]   fwd_data,
   input logic                 data_wait,
   input logic                 addr_wait,
   input logic [IDXW-1:0]      addr_wait_idx,
   input logic                 match_bad
);

   // R9: idle lookup gives a quiet early stage
   p_idle_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> (fast_fwd_mask == '0 && !fast_data_wait));

   // R9: idle lookup gives a quiet final stage
   p_idle_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> ##1 (fwd_mask == '0 && fwd_data == '0 && !data_wait && !addr_wait && !match_bad));

   // R1: only requested lanes are forwarded
   p_lane_in_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> ((fast_fwd_mask & ~$past(q_mask)) == '0));

   // R2: no older slot, nothing forwarded or waited on
   p_no_older_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_older == '0) |=> (fast_fwd_mask == '0 && !fast_data_wait));

   // R6: the reported unknown-address slot is older than the load
   p_addr_idx_older_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> ##1 (!addr_wait || ((($past(q_older, 2) >> addr_wait_idx) & 1) != 0)));

endmodule

bind stlf_forward stlf_forward_chk #(.ENTRIES(ENTRIES), .BYTES(BYTES), .LINE_W(LINE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .q_valid        (q_valid),
   .q_mask         (q_mask),
   .q_older        (q_older),
   .fast_fwd_mask  (fast_fwd_mask),
   .fast_data_wait (fast_data_wait),
   .fwd_mask       (fwd_mask),
   .fwd_data       (fwd_data),
   .data_wait      (data_wait),
   .addr_wait      (addr_wait),
   .addr_wait_idx  (addr_wait_idx),
   .match_bad      (match_bad)
);

// File: tb/stlf_forward_tb.sv
module stlf_forward_tb;
   localparam int E  = 16;
   localparam int B  = 16;
   localparam int LW = 28;
   localparam int IW = $clog2(E);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic            wr_addr_valid = 0, wr_addr_known = 0, wr_line_cover = 0;
   logic [IW-1:0]   wr_addr_idx = '0, wr_data_idx = '0, rel_idx = '0, q_pos = '0;
   logic [LW-1:0]   wr_vline = '0, wr_pline = '0, q_vline = '0, q_pline = '0;
   logic [B-1:0]    wr_mask = '0, q_mask = '0;
   logic            wr_data_valid = 0, rel_valid = 0, q_valid = 0;
   logic [8*B-1:0]  wr_data = '0;
   logic [E-1:0]    q_older = '0;
   logic [B-1:0]    fast_fwd_mask, fwd_mask;
   logic            fast_data_wait, data_wait, addr_wait, match_bad;
   logic [8*B-1:0]  fwd_data;
   logic [IW-1:0]   data_wait_idx, addr_wait_idx;

   stlf_forward #(.ENTRIES(E), .BYTES(B), .LINE_W(LW)) u_dut (.*);

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // shadow of the queue, kept from the bench's own writes
   bit            sh_alloc[E], sh_ak[E], sh_dk[E], sh_cov[E];
   logic [LW-1:0] sh_va[E], sh_pa[E];
   logic [B-1:0]  sh_m[E];

   function automatic logic [7:0] pat(int slot, int lane);
      return 8'(slot * 16 + lane);
   endfunction

   // expected results
   logic [B-1:0]   x_mask;
   logic [8*B-1:0] x_data;
   bit             x_dw, x_aw, x_mb;
   int             x_dwi, x_awi;

   task automatic model(logic v, logic [LW-1:0] va, logic [LW-1:0] pa,
                        logic [B-1:0] m, logic [E-1:0] old, int pos);
      int best_k;
      x_mask = '0; x_data = '0; x_dw = 0; x_aw = 0; x_mb = 0; x_dwi = 0; x_awi = 0;
      best_k = E + 1;
      if (!v) return;
      for (int b = 0; b < B; b++) begin
         if (m[b]) begin
            for (int k = 1; k <= E; k++) begin
               int j;
               j = (pos + E - k) % E;
               if (old[j] && sh_alloc[j] && sh_ak[j] && sh_va[j] == va &&
                   (sh_cov[j] || sh_m[j][b])) begin
                  if (sh_dk[j]) begin
                     x_mask[b] = 1'b1;
                     x_data[8*b +: 8] = pat(j, b);
                  end else if (k < best_k) begin
                     best_k = k; x_dw = 1; x_dwi = j;
                  end
                  break;
               end
            end
         end
      end
      for (int k = 1; k <= E; k++) begin
         int j;
         j = (pos + E - k) % E;
         if (old[j] && sh_alloc[j] && !sh_ak[j]) begin
            x_aw = 1; x_awi = j; break;
         end
      end
      for (int j = 0; j < E; j++) begin
         if (old[j] && sh_alloc[j] && sh_ak[j]) begin
            logic [B-1:0] em;
            bit ov, vh, ph;
            em = sh_cov[j] ? {B{1'b1}} : sh_m[j];
            ov = |(em & m);
            vh = ov && (sh_va[j] == va);
            ph = ov && (sh_pa[j] == pa);
            if (vh != ph) x_mb = 1;
         end
      end
   endtask

   task automatic chk(string req, string what, logic [8*B-1:0] act, logic [8*B-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic put_addr(int idx, logic known, logic [LW-1:0] va, logic [LW-1:0] pa,
                           logic [B-1:0] m, logic cov);
      @(negedge clk);
      wr_addr_valid = 1; wr_addr_idx = IW'(idx); wr_addr_known = known;
      wr_vline = va; wr_pline = pa; wr_mask = m; wr_line_cover = cov;
      @(negedge clk);
      wr_addr_valid = 0;
      sh_alloc[idx] = 1; sh_ak[idx] = known; sh_va[idx] = va; sh_pa[idx] = pa;
      sh_m[idx] = m; sh_cov[idx] = cov;
   endtask

   task automatic put_data(int idx);
      @(negedge clk);
      wr_data_valid = 1; wr_data_idx = IW'(idx);
      for (int b = 0; b < B; b++) wr_data[8*b +: 8] = pat(idx, b);
      @(negedge clk);
      wr_data_valid = 0;
      sh_dk[idx] = 1;
   endtask

   task automatic free_slot(int idx);
      @(negedge clk);
      rel_valid = 1; rel_idx = IW'(idx);
      @(negedge clk);
      rel_valid = 0;
      sh_alloc[idx] = 0; sh_ak[idx] = 0; sh_dk[idx] = 0;
   endtask

   // one lookup: early results checked one edge later, final two edges later
   task automatic lookup(string req, logic v, logic [LW-1:0] va, logic [LW-1:0] pa,
                         logic [B-1:0] m, logic [E-1:0] old, int pos);
      model(v, va, pa, m, old, pos);
      @(negedge clk);
      q_valid = v; q_vline = va; q_pline = pa; q_mask = m; q_older = old; q_pos = IW'(pos);
      @(negedge clk);
      q_valid = 0;
      chk({req, " R4"}, "fast_fwd_mask", fast_fwd_mask, x_mask);
      chk({req, " R5"}, "fast_data_wait", fast_data_wait, x_dw);
      @(negedge clk);
      chk({req, " R1"}, "fwd_mask", fwd_mask, x_mask);
      chk({req, " R1 R12"}, "fwd_data", fwd_data, x_data);
      chk({req, " R5"}, "data_wait", data_wait, x_dw);
      if (x_dw) chk({req, " R5"}, "data_wait_idx", data_wait_idx, x_dwi);
      chk({req, " R6"}, "addr_wait", addr_wait, x_aw);
      if (x_aw) chk({req, " R6"}, "addr_wait_idx", addr_wait_idx, x_awi);
      chk({req, " R7"}, "match_bad", match_bad, x_mb);
   endtask

   typedef struct packed {
      logic [LW-1:0] va;
      logic [LW-1:0] pa;
      logic [B-1:0]  m;
      logic [E-1:0]  old;
      logic [IW-1:0] pos;
      logic [B-1:0]  exp_mask;
   } qvec_t;

   localparam qvec_t TBL [6] = '{
      '{28'h10, 28'h810, 16'hFFFF, 16'h003F, 4'd6,  16'h0FFF},  // R3 youngest of 5/2/0
      '{28'h10, 28'h810, 16'hFFFF, 16'h1FFF, 4'd13, 16'h0FFF},  // R5 slot 12 lacks data
      '{28'h10, 28'h810, 16'hFFFF, 16'hFC03, 4'd2,  16'h0003},  // R3 wrap, R6, R7
      '{28'h20, 28'h820, 16'h00F0, 16'h0200, 4'd10, 16'h00F0},  // R8 line cover
      '{28'h10, 28'h810, 16'h0030, 16'h0004, 4'd3,  16'h0030},  // R2 partial overlap
      '{28'h11, 28'h811, 16'hFFFF, 16'h003F, 4'd6,  16'h0000}   // R2 other line
   };

   initial begin
      for (int i = 0; i < E; i++) begin
         sh_alloc[i] = 0; sh_ak[i] = 0; sh_dk[i] = 0; sh_cov[i] = 0;
         sh_va[i] = '0; sh_pa[i] = '0; sh_m[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk("R10", "fast_fwd_mask", fast_fwd_mask, '0);
      chk("R10", "fwd_mask", fwd_mask, '0);
      chk("R10", "fwd_data", fwd_data, '0);
      chk("R10", "flags", {fast_data_wait, data_wait, addr_wait, match_bad}, '0);
      lookup("R10 empty", 1'b1, 28'h10, 28'h810, 16'hFFFF, 16'hFFFF, 0);

      put_addr(0,  1, 28'h10, 28'h810, 16'h0001, 0); put_data(0);
      put_addr(2,  1, 28'h10, 28'h810, 16'h00FF, 0); put_data(2);
      put_addr(5,  1, 28'h10, 28'h810, 16'h0F0F, 0); put_data(5);
      put_addr(9,  1, 28'h20, 28'h820, 16'h0001, 1); put_data(9);
      put_addr(12, 1, 28'h10, 28'h810, 16'hF000, 0);
      put_addr(14, 0, 28'h00, 28'h000, 16'h0000, 0);
      put_addr(15, 1, 28'h10, 28'h910, 16'h0003, 0); put_data(15);

      for (int i = 0; i < 6; i++) begin
         lookup($sformatf("R2 R3 vec%0d", i), 1'b1, TBL[i].va, TBL[i].pa, TBL[i].m,
                TBL[i].old, int'(TBL[i].pos));
         chk("R1 table", "fwd_mask", fwd_mask, TBL[i].exp_mask);
      end

      // R9: fields present but valid low
      lookup("R9 idle", 1'b0, 28'h10, 28'h810, 16'hFFFF, 16'hFFFF, 6);
      chk("R9", "fwd_mask", fwd_mask, '0);

      // R11: released slot drops out
      free_slot(5);
      lookup("R11 release", 1'b1, 28'h10, 28'h810, 16'hFFFF, 16'h003F, 6);
      chk("R11", "fwd_mask", fwd_mask, 16'h00FF);

      // R5: data arrives, wait clears
      put_data(12);
      lookup("R5 filled", 1'b1, 28'h10, 28'h810, 16'hFFFF, 16'h1FFF, 13);
      chk("R5", "data_wait", data_wait, 1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule